// File: doc/BRIEF.md
# LIN Slave Baud-Rate Synchronizer

This block lets a LIN slave node adopt the bit rate of the master. It watches the serial receive line for a header. A header is a long dominant (low) break, a recessive delimiter, and then the synch byte 0x55 with its start and stop bits. The block times eight bit periods of that byte with a counter that advances once every oversampling period. It then splits the count into a 16-bit integer clock divider and a 3-bit fractional divider. A UART receiver reads these through `cd_o` and `fp_o`.

While `en_i` is low, the divider register copies the initial values presented by the host logic. Once `en_i` is high, the register changes only at the end of a properly framed synch field. A one-cycle `upd_o` strobe marks each successful load. A one-cycle `err_o` strobe marks a measurement that cannot be used, and in that case the register is left as it was. Break detection measures the low time against the divider currently in force. Its default threshold is eleven bit periods, which is a 13-bit break sent by a master running up to 15% fast.

Top module: `lin_baud_sync`

## Requirements
- R1: While `rst_n` is low, `cd_o`, `fp_o`, `upd_o` and `err_o` are zero. While `en_i` is low, each clock loads `init_cd_i`/`init_fp_i` into the register, with no strobe, and any header in progress is abandoned. If `en_i` is low in the same clock as a load would occur, the initial values win and `upd_o` stays low.
- R2: A header is armed only when the synchronized line stays low for at least BRK_MIN (default 11) bit periods of the register in force and then rises. One bit period is Over×(cd + fp/8) clocks. A shorter low leaves the outputs untouched.
- R3: After arming, the next falling edge clears the count. The count then advances once every Over clocks, where Over is 8 when `over8_i`=1 and 16 when `over8_i`=0. It stops at the fifth falling edge counted from the start bit. For bits of N clocks the count is floor(8N/Over).
- R4: The new divider is count bits [CNT_W-1:3] and the new fraction is count bits [2:0].
- R5: The register changes only on the rising edge of the stop bit, three clocks after `rxd_i` rises (two synchronizer stages plus the register). In that same clock `upd_o` is high for exactly one cycle. Outside that clock `cd_o`/`fp_o` hold while `en_i` is high.
- R6: If the count exceeds CNT_W bits (default 19), or if the new divider would be zero, `err_o` pulses for one cycle in place of `upd_o` and the register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial receive line, asynchronous |
| en_i | input | 1 | Synchronization enable; low loads initial values |
| over8_i | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| init_cd_i | input | CNT_W-3 | Initial integer divider |
| init_fp_i | input | 3 | Initial fractional divider |
| cd_o | output | CNT_W-3 | Integer divider in force |
| fp_o | output | 3 | Fractional divider in force |
| upd_o | output | 1 | One-cycle strobe: register loaded from a measurement |
| err_o | output | 1 | One-cycle strobe: measurement rejected |

## Verification
The load at the stop-bit edge and the copy of the initial values when `en_i` is low can both claim the divider register in the same clock. The bench provokes this by dropping `en_i` two clocks after driving the stop-bit rise, so that the disable reaches the register in exactly the cycle the edge is acted on. The reference model then expects the initial values and no `upd_o` strobe. The per-clock comparison reports any cycle where the measured value appears instead or a strobe leaks out.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;
    localparam int FP_W = 3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT_START,
        S_MEASURE,
        S_WAIT_STOP
    } sync_st_e;
endpackage

// File: rtl/lin_rx_edge.sv
module lin_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    output logic lvl_o,
    output logic fall_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d      = edge_q;
        edge_d.sh   = {edge_q.sh[STAGES-2:0], rxd_i};
        edge_d.prev = edge_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '1;
        else        edge_q <= edge_d;
    end

    assign lvl_o  = edge_q.sh[STAGES-1];
    assign fall_o = edge_q.prev & ~lvl_o;
    assign rise_o = ~edge_q.prev & lvl_o;
endmodule

// File: rtl/lin_break_meter.sv
module lin_break_meter
    import lin_sync_pkg::*;
#(
    parameter int CNT_W   = 19,
    parameter int BRK_MIN = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lvl_i,
    input  logic                   over8_i,
    input  logic [CNT_W-FP_W-1:0]  cd_i,
    input  logic [FP_W-1:0]        fp_i,
    output logic                   long_o
);
    localparam int LIM_W = CNT_W + 4 + $clog2(BRK_MIN + 1) + 1;

    logic [LIM_W-1:0] per8, lim;
    logic [LIM_W-1:0] low_d, low_q;

    // period in eighths of a clock count, scaled by the oversampling ratio
    always_comb begin
        per8 = LIM_W'({cd_i, fp_i}) << (over8_i ? 3'd3 : 3'd4);
        lim  = per8 * LIM_W'(BRK_MIN);
    end

    always_comb begin
        if (lvl_i)           low_d = '0;
        else if (low_q < lim) low_d = low_q + LIM_W'(8);
        else                 low_d = low_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

    assign long_o = (low_q >= lim);
endmodule

// File: rtl/lin_synch_meter.sv
module lin_synch_meter #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             over8_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [3:0]       pre;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } meter_t;

    meter_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (clr_i) begin
            m_d = '0;
        end else if (run_i) begin
            if (m_q.pre == (over8_i ? 4'd7 : 4'd15)) begin
                m_d.pre = '0;
                m_d.cnt = m_q.cnt + CNT_W'(1);
                if (m_q.cnt == '1) m_d.ovf = 1'b1;
            end else begin
                m_d.pre = m_q.pre + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign cnt_o = m_q.cnt;
    assign ovf_o = m_q.ovf;
endmodule

// File: rtl/lin_baud_sync.sv
module lin_baud_sync
    import lin_sync_pkg::*;
#(
    parameter int CNT_W       = 19,
    parameter int BRK_MIN     = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rxd_i,
    input  logic                  en_i,
    input  logic                  over8_i,
    input  logic [CNT_W-FP_W-1:0] init_cd_i,
    input  logic [FP_W-1:0]       init_fp_i,
    output logic [CNT_W-FP_W-1:0] cd_o,
    output logic [FP_W-1:0]       fp_o,
    output logic                  upd_o,
    output logic                  err_o
);
    localparam int CD_W = CNT_W - FP_W;

    typedef struct packed {
        sync_st_e        st;
        logic [1:0]      nfall;
        logic [CD_W-1:0] cd;
        logic [FP_W-1:0] fp;
        logic            upd;
        logic            err;
    } sync_t;

    sync_t s_d, s_q;

    logic             rx_lvl, rx_fall, rx_rise;
    logic             long_low;
    logic             meas_clr, meas_run;
    logic [CNT_W-1:0] meter_cnt;
    logic             meter_ovf;
    sync_st_e         st_now;

    lin_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd_i  (rxd_i),
        .lvl_o  (rx_lvl),
        .fall_o (rx_fall),
        .rise_o (rx_rise)
    );

    lin_break_meter #(.CNT_W(CNT_W), .BRK_MIN(BRK_MIN)) u_break (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (rx_lvl),
        .over8_i (over8_i),
        .cd_i    (s_q.cd),
        .fp_i    (s_q.fp),
        .long_o  (long_low)
    );

    assign meas_clr = en_i && (s_q.st == S_WAIT_START) && rx_fall;
    assign meas_run = (s_q.st == S_MEASURE);

    lin_synch_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (meas_clr),
        .run_i   (meas_run),
        .over8_i (over8_i),
        .cnt_o   (meter_cnt),
        .ovf_o   (meter_ovf)
    );

    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        s_d.err = 1'b0;
        if (!en_i) begin
            s_d.st    = S_IDLE;
            s_d.nfall = '0;
            s_d.cd    = init_cd_i;
            s_d.fp    = init_fp_i;
        end else begin
            case (s_q.st)
                S_IDLE: begin
                    if (rx_rise && long_low) s_d.st = S_WAIT_START;
                end
                S_WAIT_START: begin
                    if (rx_fall) begin
                        s_d.st    = S_MEASURE;
                        s_d.nfall = '0;
                    end
                end
                S_MEASURE: begin
                    // start bit already seen; the fourth edge here closes eight bit times
                    if (rx_fall) begin
                        if (s_q.nfall == 2'd3) s_d.st = S_WAIT_STOP;
                        else                   s_d.nfall = s_q.nfall + 2'd1;
                    end
                end
                S_WAIT_STOP: begin
                    if (rx_rise) begin
                        s_d.st = S_IDLE;
                        if (meter_ovf || (meter_cnt[CNT_W-1:FP_W] == '0)) begin
                            s_d.err = 1'b1;
                        end else begin
                            s_d.cd  = meter_cnt[CNT_W-1:FP_W];
                            s_d.fp  = meter_cnt[FP_W-1:0];
                            s_d.upd = 1'b1;
                        end
                    end
                end
                default: s_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_now = s_q.st;
    assign cd_o   = s_q.cd;
    assign fp_o   = s_q.fp;
    assign upd_o  = s_q.upd;
    assign err_o  = s_q.err;
endmodule

// File: rtl/lin_baud_sync_chk.sv
module lin_baud_sync_chk
    import lin_sync_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  en_i,
    input logic [CNT_W-FP_W-1:0] init_cd_i,
    input logic [FP_W-1:0]       init_fp_i,
    input logic [CNT_W-FP_W-1:0] cd_o,
    input logic [FP_W-1:0]       fp_o,
    input logic                  upd_o,
    input logic                  err_o,
    input logic                  rx_rise,
    input logic                  long_low,
    input sync_st_e              st_now,
    input logic [CNT_W-1:0]      meter_cnt
);
    AST_DISABLED_FOLLOWS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cd_o == $past(init_cd_i)) && (fp_o == $past(init_fp_i)) && !upd_o && !err_o); // R1

    AST_SHORT_LOW_NOT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_now == S_IDLE && rx_rise && !long_low) |=> (st_now == S_IDLE)); // R2

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_now == S_WAIT_STOP) |=> $stable(meter_cnt)); // R3

    AST_LOAD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> ({cd_o, fp_o} == $past(meter_cnt))); // R4

    AST_HOLD_WITHOUT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && !upd_o) |-> ($stable(cd_o) && $stable(fp_o))); // R5

    AST_STROBE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o || err_o) |-> $past(rx_rise)); // R5

    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o); // R5

    AST_ERR_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(cd_o) && $stable(fp_o) && !upd_o)); // R6

    AST_UPD_NONZERO_CD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (cd_o != '0)); // R6
endmodule

bind lin_baud_sync lin_baud_sync_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .init_cd_i (init_cd_i),
    .init_fp_i (init_fp_i),
    .cd_o      (cd_o),
    .fp_o      (fp_o),
    .upd_o     (upd_o),
    .err_o     (err_o),
    .rx_rise   (rx_rise),
    .long_low  (long_low),
    .st_now    (st_now),
    .meter_cnt (meter_cnt)
);

// File: tb/test_lin_baud_sync.sv
module test_lin_baud_sync;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rxd, en, over8;
    logic [15:0] init_cd;
    logic [2:0]  init_fp;
    logic [15:0] cd;
    logic [2:0]  fp;
    logic        upd, err;
    logic [6:0]  s_cd;
    logic [2:0]  s_fp;
    logic        s_upd, s_err;

    always #5 clk = ~clk;

    lin_baud_sync i_lin_baud_sync (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .en_i(en), .over8_i(over8),
        .init_cd_i(init_cd), .init_fp_i(init_fp),
        .cd_o(cd), .fp_o(fp), .upd_o(upd), .err_o(err)
    );

    // narrow-counter copy, used only to reach the overflow case quickly
    lin_baud_sync #(.CNT_W(10)) i_lin_baud_sync_small (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .en_i(en), .over8_i(over8),
        .init_cd_i(init_cd[6:0]), .init_fp_i(init_fp),
        .cd_o(s_cd), .fp_o(s_fp), .upd_o(s_upd), .err_o(s_err)
    );

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    int exp_cd = 0, exp_fp = 0;
    bit exp_upd = 0, exp_err = 0;
    bit armed = 0;
    int dly = 0;
    int p_cd = 0, p_fp = 0;
    bit p_err = 0;
    bit mon_on = 0;
    int upd_seen = 0, err_seen = 0, s_err_seen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (mon_on) begin
            exp_upd = 0;
            exp_err = 0;
            if (!en) begin
                exp_cd = init_cd;
                exp_fp = init_fp;
                armed  = 0;
            end else if (armed) begin
                dly--;
                if (dly == 0) begin
                    armed = 0;
                    if (p_err) exp_err = 1;
                    else begin
                        exp_cd  = p_cd;
                        exp_fp  = p_fp;
                        exp_upd = 1;
                    end
                end
            end
            check(cd == exp_cd, "R5", "cd", cd, exp_cd);
            check(fp == exp_fp, "R5", "fp", fp, exp_fp);
            check(upd == exp_upd, "R5", "upd", upd, exp_upd);
            check(err == exp_err, "R6", "err", err, exp_err);
            if (upd) upd_seen++;
            if (err) err_seen++;
            if (s_err) s_err_seen++;
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // break of brk bit times, delimiter, then 0x55 framed; every bit lasts n clocks
    task automatic send_header(input int n, input int brk, input bit ov, input bit drop_en);
        int  ovv;
        int  cnt;
        bit  valid;
        logic [9:0] frame;
        @(negedge clk);
        over8 = ov;
        ovv   = ov ? 8 : 16;
        cnt   = (8 * n) / ovv;
        valid = en && (longint'(brk) * n * 8 >= longint'(11) * ovv * (8 * exp_cd + exp_fp));
        frame = {1'b1, 8'h55, 1'b0};
        rxd = 1'b0;
        hold(brk * n);
        rxd = 1'b1;
        hold(n);
        for (int i = 0; i < 10; i++) begin
            rxd = frame[i];
            if (i == 9 && valid) begin
                armed = 1;
                dly   = 3;
                p_cd  = cnt >> 3;
                p_fp  = cnt & 7;
                p_err = (cnt >= (1 << 19)) || ((cnt >> 3) == 0);
            end
            if (i == 9 && drop_en) begin
                hold(2);
                en = 1'b0;
                hold(n - 2);
            end else begin
                hold(n);
            end
        end
        hold(30);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        int before_upd;
        int before_err;
        int s_before;
        rst_n = 1'b0; rxd = 1'b1; en = 1'b0; over8 = 1'b0;
        init_cd = 16'd6; init_fp = 3'd4;
        hold(4);
        // R1: reset state
        check(cd == 0 && fp == 0, "R1", "reset cd/fp", {cd, fp}, 0);
        check(upd == 0 && err == 0, "R1", "reset strobes", {upd, err}, 0);
        rst_n = 1'b1;
        mon_on = 1;
        hold(3);
        check(cd == 6 && fp == 4, "R1", "init copy", {cd, fp}, {16'd6, 3'd4});
        init_cd = 16'd9; init_fp = 3'd5;
        hold(3);
        check(cd == 9 && fp == 5, "R1", "init follows", {cd, fp}, {16'd9, 3'd5});
        init_cd = 16'd6; init_fp = 3'd4;
        hold(3);
        en = 1'b1;
        hold(5);

        // R3/R4: 16x, 100-clock bits -> count 50 -> cd 6 fp 2
        before_upd = upd_seen;
        send_header(100, 13, 1'b0, 1'b0);
        check(cd == 6 && fp == 2, "R4", "16x sync", {cd, fp}, {16'd6, 3'd2});
        check(upd_seen - before_upd == 1, "R5", "one upd pulse", upd_seen - before_upd, 1);

        // R3: slower master -> count 59 -> cd 7 fp 3
        send_header(118, 13, 1'b0, 1'b0);
        check(cd == 7 && fp == 3, "R3", "slower master", {cd, fp}, {16'd7, 3'd3});

        // R2: too-short break leaves register untouched
        before_upd = upd_seen;
        before_err = err_seen;
        send_header(118, 9, 1'b0, 1'b0);
        check(cd == 7 && fp == 3, "R2", "short break value", {cd, fp}, {16'd7, 3'd3});
        check(upd_seen == before_upd && err_seen == before_err, "R2", "short break strobes",
              upd_seen - before_upd + err_seen - before_err, 0);

        // R3: 8x ratio, 60-clock bits -> count 60 -> cd 7 fp 4
        send_header(60, 13, 1'b1, 1'b0);
        check(cd == 7 && fp == 4, "R3", "8x sync", {cd, fp}, {16'd7, 3'd4});

        // R6: divider would be zero
        before_err = err_seen;
        send_header(12, 120, 1'b0, 1'b0);
        check(cd == 7 && fp == 4, "R6", "zero cd kept", {cd, fp}, {16'd7, 3'd4});
        check(err_seen - before_err == 1, "R6", "zero cd err pulse", err_seen - before_err, 1);

        // R6: overflow of the narrow copy; wide copy loads count 1100
        s_before   = s_cd;
        before_err = s_err_seen;
        send_header(1100, 13, 1'b1, 1'b0);
        check(cd == 137 && fp == 4, "R4", "long bit sync", {cd, fp}, {16'd137, 3'd4});
        check(s_err_seen - before_err == 1, "R6", "overflow err pulse", s_err_seen - before_err, 1);
        check(s_cd == s_before, "R6", "overflow keeps cd", s_cd, s_before);

        // R1: disable coincides with the stop-bit load
        before_upd = upd_seen;
        send_header(60, 210, 1'b1, 1'b1);
        check(cd == 6 && fp == 4, "R1", "disable wins", {cd, fp}, {16'd6, 3'd4});
        check(upd_seen == before_upd, "R1", "no upd on disable", upd_seen - before_upd, 0);
        en = 1'b1;
        hold(10);
        finish_run();
    end
endmodule